// File: doc/BRIEF.md
# Gated Serial Clock Divider

This block derives the serial clock for a flash-style serial controller from the controller clock. The serial clock idles low. Each level lasts a power-of-two number of controller cycles, and a 2-bit code selects that count. The block also gives the transfer sequencer one-cycle shift and sample enables that line up with the serial clock edges. A phase select decides which edge shifts and which edge samples.

Software may not retune the divider while the clock runs. To change it, software clears both gate enables and waits for the stopped status. It then writes the new code and sets an enable again. The gate only closes while the serial clock is low, so no shortened pulse reaches the pins. The divider code and the phase select are taken into the active configuration only while the clock is stopped. A combined status output tells software when reconfiguration is safe: the clock is stopped, the sequencer is idle, and there is no bus read or write activity.

Top module: `spi_clk_gate_div`

## Requirements
- R1: With active divider code c, let N = 2^c (code 0 gives 1, 1 gives 2, 2 gives 4, 3 gives 8). Every serial clock level lasts exactly N controller cycles. The first rising edge appears N+1 cycles after the enable is seen.
- R2: The clock runs while either enable (`runEn` or `bootEn`) is set. It stops only when both are clear.
- R3: After the enables clear, the serial clock never rises again. A high level already in progress still lasts the full N cycles. The clock then rests low.
- R4: `clkStopped` rises exactly two cycles after the first cycle in which the serial clock is low with both enables clear.
- R5: `clkStopped` falls exactly two cycles after an enable is set while the clock is stopped.
- R6: The divider code and phase select are captured only while the clock is stopped. `activeDiv` reports the captured code. A code change while running has no effect on the period or on `activeDiv` until the next stop.
- R7: With phase 0 (180 degrees), `sampleEn` pulses on rising edges and `shiftEn` pulses on falling edges. Phase 1 (90 degrees) swaps them. Each pulse lasts one cycle, in the first cycle of the new level, and no pulse occurs without an edge.
- R8: `engineIdle` follows the inverse of `seqBusy` one cycle later. `cfgSafe` is high only when `clkStopped` and `engineIdle` are high and `busRd` and `busWr` are low.
- R9: After reset, `sclk`, `shiftEn` and `sampleEn` are low, `clkStopped` and `engineIdle` are high, and `activeDiv` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rstN | input | 1 | Asynchronous active-low reset |
| runEn | input | 1 | Normal clock gate enable |
| bootEn | input | 1 | Boot-path clock gate enable |
| phaseSel | input | 1 | 0 = 180-degree phase, 1 = 90-degree phase |
| divCode | input | 2 | Requested divider code |
| seqBusy | input | 1 | Transfer sequencer is active |
| busRd | input | 1 | Host bus read in progress |
| busWr | input | 1 | Host bus write in progress |
| sclk | output | 1 | Serial clock, idle low |
| shiftEn | output | 1 | One-cycle shift enable |
| sampleEn | output | 1 | One-cycle sample enable |
| clkStopped | output | 1 | Serial clock is gated off |
| engineIdle | output | 1 | Registered sequencer idle status |
| cfgSafe | output | 1 | Reconfiguration is safe |
| activeDiv | output | 2 | Divider code in use |

## Verification
The assertions check four properties on every cycle. Enables pulse only on a serial clock edge, and never both at once. The clock stays low whenever the gate is off. The stopped status rises only after two low cycles. The active code holds steady while running. Exact cycle counts can only be shown by the bench's sweep over every code, phase and gate-off offset: the half period, the first-edge latency, the two-cycle status latency in both directions, and the capture of a code written mid-run only after the stop.

// File: rtl/spi_clk_gate_pkg.sv
package spi_clk_gate_pkg;
  localparam int DIV_CODE_W = 2;
  localparam int CNT_W      = (1 << DIV_CODE_W) - 1;

  typedef struct packed {
    logic                  run;
    logic                  holdLow;
    logic                  phase;
    logic [DIV_CODE_W-1:0] div;
  } ctrlStrobe_t;
endpackage

// File: rtl/spi_clk_gate_dp.sv
module spi_clk_gate_dp
  import spi_clk_gate_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  ctrlStrobe_t strb,
  output logic        sclk,
  output logic        shiftEn,
  output logic        sampleEn
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] lim;
  logic             edgeDue;
  logic             blockRise;

  always_comb begin
    lim       = CNT_W'((1 << strb.div) - 1);
    edgeDue   = (cnt == lim);
    blockRise = !sclk && strb.holdLow;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt      <= '0;
      sclk     <= 1'b0;
      shiftEn  <= 1'b0;
      sampleEn <= 1'b0;
    end else if (!strb.run) begin
      cnt      <= '0;
      sclk     <= 1'b0;
      shiftEn  <= 1'b0;
      sampleEn <= 1'b0;
    end else if (edgeDue && !blockRise) begin
      cnt      <= '0;
      sclk     <= ~sclk;
      shiftEn  <= sclk ^ strb.phase;
      sampleEn <= ~(sclk ^ strb.phase);
    end else begin
      cnt      <= edgeDue ? '0 : cnt + CNT_W'(1);
      shiftEn  <= 1'b0;
      sampleEn <= 1'b0;
    end
  end

  assert_pulse_on_edge_R7: assert property (@(posedge clk) disable iff (!rstN)
    (shiftEn || sampleEn) |-> (sclk != $past(sclk)));
  assert_no_dual_pulse_R7: assert property (@(posedge clk) disable iff (!rstN)
    !(shiftEn && sampleEn));
endmodule

// File: rtl/spi_clk_gate_ctrl.sv
module spi_clk_gate_ctrl
  import spi_clk_gate_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  runEn,
  input  logic                  bootEn,
  input  logic                  phaseSel,
  input  logic [DIV_CODE_W-1:0] divCode,
  input  logic                  seqBusy,
  input  logic                  sclk,
  output ctrlStrobe_t           strb,
  output logic                  stoppedQ,
  output logic                  idleQ,
  output logic [DIV_CODE_W-1:0] divQ
);
  logic gateReq;
  logic runQ;
  logic phaseQ;

  assign gateReq = runEn | bootEn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runQ     <= 1'b0;
      stoppedQ <= 1'b1;
      divQ     <= '0;
      phaseQ   <= 1'b0;
      idleQ    <= 1'b1;
    end else begin
      if (!runQ && gateReq)
        runQ <= 1'b1;
      else if (runQ && !gateReq && !sclk)
        runQ <= 1'b0;
      stoppedQ <= !runQ;
      if (stoppedQ && !runQ) begin
        divQ   <= divCode;
        phaseQ <= phaseSel;
      end
      idleQ <= !seqBusy;
    end
  end

  always_comb begin
    strb.run     = runQ;
    strb.holdLow = !gateReq;
    strb.phase   = phaseQ;
    strb.div     = divQ;
  end

  assert_rest_low_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!runQ && $past(!runQ)) |-> !sclk);
  assert_stop_after_low_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(stoppedQ) |-> (!sclk && $past(!sclk)));
  assert_div_frozen_R6: assert property (@(posedge clk) disable iff (!rstN)
    runQ |=> $stable(divQ));
endmodule

// File: rtl/spi_clk_gate_div.sv
module spi_clk_gate_div
  import spi_clk_gate_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  runEn,
  input  logic                  bootEn,
  input  logic                  phaseSel,
  input  logic [DIV_CODE_W-1:0] divCode,
  input  logic                  seqBusy,
  input  logic                  busRd,
  input  logic                  busWr,
  output logic                  sclk,
  output logic                  shiftEn,
  output logic                  sampleEn,
  output logic                  clkStopped,
  output logic                  engineIdle,
  output logic                  cfgSafe,
  output logic [DIV_CODE_W-1:0] activeDiv
);
  ctrlStrobe_t strb;

  spi_clk_gate_ctrl ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .runEn    (runEn),
    .bootEn   (bootEn),
    .phaseSel (phaseSel),
    .divCode  (divCode),
    .seqBusy  (seqBusy),
    .sclk     (sclk),
    .strb     (strb),
    .stoppedQ (clkStopped),
    .idleQ    (engineIdle),
    .divQ     (activeDiv)
  );

  spi_clk_gate_dp dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .sclk     (sclk),
    .shiftEn  (shiftEn),
    .sampleEn (sampleEn)
  );

  assign cfgSafe = clkStopped & engineIdle & ~busRd & ~busWr;

  assert_safe_clock_low_R8: assert property (@(posedge clk) disable iff (!rstN)
    cfgSafe |-> !sclk);
endmodule

// File: tb/spi_clk_gate_div_tb.sv
module spi_clk_gate_div_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       runEn = 1'b0, bootEn = 1'b0, phaseSel = 1'b0;
  logic [1:0] divCode = 2'd0;
  logic       seqBusy = 1'b0, busRd = 1'b0, busWr = 1'b0;
  logic       sclk, shiftEn, sampleEn, clkStopped, engineIdle, cfgSafe;
  logic [1:0] activeDiv;

  int nChecks = 0, nFails = 0;
  int mN, mK, mSince;
  bit mPh, mPrev, mArmed;

  always #4 clk = ~clk;

  spi_clk_gate_div dut_i (
    .clk(clk), .rstN(rstN), .runEn(runEn), .bootEn(bootEn), .phaseSel(phaseSel),
    .divCode(divCode), .seqBusy(seqBusy), .busRd(busRd), .busWr(busWr),
    .sclk(sclk), .shiftEn(shiftEn), .sampleEn(sampleEn), .clkStopped(clkStopped),
    .engineIdle(engineIdle), .cfgSafe(cfgSafe), .activeDiv(activeDiv)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one sample step at the falling edge, with edge and pulse bookkeeping
  task automatic step(output bit changed);
    @(negedge clk);
    mK++;
    mSince++;
    changed = (sclk != mPrev);
    if (changed) begin
      if (!mArmed) begin
        check(mK == mN + 1, "R1 first rise latency (R2 gate open)", mK, mN + 1);
        mArmed = 1'b1;
      end else begin
        check(mSince == mN, "R1 level length", mSince, mN);
      end
      check(shiftEn == (sclk ? mPh : !mPh), "R7 shift pulse on edge", shiftEn, sclk ? mPh : !mPh);
      check(sampleEn == (sclk ? !mPh : mPh), "R7 sample pulse on edge", sampleEn, sclk ? !mPh : mPh);
      mSince = 0;
      mPrev = sclk;
    end else begin
      check(!shiftEn && !sampleEn, "R7 no pulse without edge", {shiftEn, sampleEn}, 0);
    end
  endtask

  task automatic runCase(input int code, input bit ph, input bit useBoot, input int offset);
    bit ch;
    int expStop, stopAt, newCode;
    newCode = code ^ 1;
    @(negedge clk);
    divCode = 2'(code);
    phaseSel = ph;
    @(negedge clk);
    mN = 1 << code; mPh = ph; mK = 0; mSince = 0; mPrev = 1'b0; mArmed = 1'b0;
    if (useBoot) bootEn = 1'b1; else runEn = 1'b1;
    step(ch);
    check(clkStopped == 1'b1, "R5 still stopped one cycle after enable", clkStopped, 1);
    step(ch);
    check(clkStopped == 1'b0, "R5 running two cycles after enable", clkStopped, 0);
    for (int i = 0; i < 6 * mN; i++) begin
      step(ch);
      if (i == 2) divCode = 2'(newCode);
    end
    check(activeDiv == 2'(code), "R6 code held while running", activeDiv, code);
    for (int i = 0; i < offset; i++) step(ch);
    expStop = (sclk ? (mN - mSince) : 0) + 2;
    runEn = 1'b0;
    bootEn = 1'b0;
    mK = 0;
    stopAt = -1;
    for (int k = 1; k <= 40 && stopAt < 0; k++) begin
      step(ch);
      if (ch && sclk) check(1'b0, "R3 rise after gate off", 1, 0);
      if (clkStopped) stopAt = k;
    end
    check(stopAt == expStop, "R4 stopped status latency", stopAt, expStop);
    check(sclk == 1'b0, "R3 clock rests low (R2 both clear)", sclk, 0);
    step(ch);
    check(activeDiv == 2'(newCode), "R6 new code captured after stop", activeDiv, newCode);
  endtask

  initial begin
    #(8 * 150000);
    nFails++;
    $display("FAIL watchdog expired (all requirements) actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(sclk == 1'b0, "R9 reset sclk", sclk, 0);
    check(!shiftEn && !sampleEn, "R9 reset pulses", {shiftEn, sampleEn}, 0);
    check(clkStopped == 1'b1, "R9 reset stopped", clkStopped, 1);
    check(engineIdle == 1'b1, "R9 reset idle", engineIdle, 1);
    check(activeDiv == 2'd0, "R9 reset divider", activeDiv, 0);

    // R8 status combination while stopped
    check(cfgSafe == 1'b1, "R8 safe when quiet", cfgSafe, 1);
    busRd = 1'b1;
    #1 check(cfgSafe == 1'b0, "R8 bus read blocks", cfgSafe, 0);
    busRd = 1'b0; busWr = 1'b1;
    #1 check(cfgSafe == 1'b0, "R8 bus write blocks", cfgSafe, 0);
    busWr = 1'b0;
    seqBusy = 1'b1;
    @(negedge clk);
    check(engineIdle == 1'b0, "R8 idle follows busy", engineIdle, 0);
    check(cfgSafe == 1'b0, "R8 busy blocks", cfgSafe, 0);
    seqBusy = 1'b0;
    @(negedge clk);
    check(engineIdle == 1'b1 && cfgSafe == 1'b1, "R8 idle restored", {engineIdle, cfgSafe}, 3);

    for (int c = 0; c < 4; c++)
      for (int off = 0; off < 2 * (1 << c); off++)
        runCase(c, 1'b0, 1'b0, off);
    for (int c = 0; c < 4; c++) begin
      runCase(c, 1'b1, 1'b1, 1 << c);
      runCase(c, 1'b1, 1'b0, 1);
    end

    // R8: running clock is never safe
    runEn = 1'b1;
    repeat (4) @(negedge clk);
    check(cfgSafe == 1'b0, "R8 unsafe while running", cfgSafe, 0);
    runEn = 1'b0;
    repeat (40) @(negedge clk);
    check(clkStopped == 1'b1, "R2 stopped after both clear", clkStopped, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule